// File: doc/BRIEF.md
# Port Change-Detect Interrupt

This block watches the upper four pins of an 8-bit port and raises a sticky change flag when an enabled input pin no longer matches its reference value. The reference is a snapshot of those pins. The snapshot is not the previous clock's sample. It is taken whenever software reads or writes the port, so a change is reported against what software last saw. The flag also drives an interrupt request line, which can serve directly as a wake request.

Each watched pin has its own enable bit, and a pin whose direction bit marks it as an output is left out of the comparison. A global enable gates the interrupt request. Software clears the flag with a clear strobe. A clear has no effect while any enabled mismatch remains, so the usual sequence is to access the port and then clear the flag.

There are two reset inputs. The power-on reset loads the snapshot from the live pins and clears the flag. The system reset clears only the flag and leaves the snapshot as it is. If a mismatch is still present after a system reset, the flag sets again.

Top module: `port_ioc_detect`

## Requirements
- R1: After power-on reset is released with the pins steady, `flag_o` and `irq_o` are 0 and stay 0. The snapshot holds the pin levels present during reset.
- R2: A pin among 7..4 sets `flag_o` on the next rising clock edge when all of these hold: its direction bit is 1 (input), its bit in `pin_en_i` is 1 (bit k of `pin_en_i` belongs to pin k+4), and its level differs from the snapshot. Once set, the flag stays set until it is cleared.
- R3: A pin whose `pin_en_i` bit is 0 never sets the flag.
- R4: A pin whose `dir_in_i` bit is 0 (output) never sets the flag, even when its enable bit is 1.
- R5: Pins 3..0 never affect the flag, whatever their levels and direction bits.
- R6: `irq_o` is 1 exactly when `flag_o` is 1 and `glob_en_i` is 1. The flag still records changes while `glob_en_i` is 0.
- R7: A cycle with `port_rd_i` or `port_wr_i` high loads the snapshot from pins 7..4. This ends the mismatch, and a clear in that same cycle takes effect.
- R8: A `flag_clr_i` pulse without a port access leaves `flag_o` at 1 while an enabled mismatch persists.
- R9: A `flag_clr_i` pulse with no enabled mismatch clears `flag_o` on the next edge.
- R10: The system reset (`rst_n` low) clears the flag and keeps the snapshot. After release, a remaining mismatch sets the flag again on the next edge.
- R11: A pin change that arrives in the same cycle as a port access goes into the snapshot and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; reloads the snapshot |
| rst_n | input | 1 | System reset, active low, synchronous; clears only the flag |
| pins_i | input | 8 | Synchronized port pin levels |
| dir_in_i | input | 8 | Direction per pin, 1 = input |
| pin_en_i | input | 4 | Change-detect enable for pins 7..4 (bit k = pin k+4) |
| glob_en_i | input | 1 | Global interrupt enable |
| port_rd_i | input | 1 | Port read strobe |
| port_wr_i | input | 1 | Port write strobe |
| flag_clr_i | input | 1 | Flag clear strobe |
| flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Interrupt and wake request |

## Verification
The assertions assume that every input is synchronous to `clk` and stable at each rising edge, and that `por_n` is held low for at least one edge before any other check is meaningful. The bench meets these assumptions by changing its inputs only just after a rising edge and by starting with several power-on reset cycles. The strobes are driven as single-cycle pulses, apart from the deliberate overlap of an access with a clear or with a pin change.

// File: rtl/port_ioc_detect.sv
module port_ioc_detect #(
  parameter int PORT_W = 8,
  parameter int IOC_W  = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pins_i,
  input  logic [PORT_W-1:0] dir_in_i,
  input  logic [IOC_W-1:0]  pin_en_i,
  input  logic              glob_en_i,
  input  logic              port_rd_i,
  input  logic              port_wr_i,
  input  logic              flag_clr_i,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int LO = PORT_W - IOC_W;

  logic [IOC_W-1:0] live, snap, watch, diff;
  logic             access, mism;

  assign live   = pins_i[PORT_W-1:LO];
  assign watch  = pin_en_i & dir_in_i[PORT_W-1:LO];
  assign access = port_rd_i | port_wr_i;
  assign diff   = (live ^ snap) & watch;
  assign mism   = (|diff) & ~access;

  logic unused_low;
  assign unused_low = ^{pins_i[LO-1:0], dir_in_i[LO-1:0]};

  always_ff @(posedge clk) begin
    if (!por_n || access) snap <= live;
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) flag_o <= 1'b0;
    else                  flag_o <= mism | (flag_o & ~flag_clr_i);
  end

  assign irq_o = flag_o & glob_en_i;
endmodule

// File: rtl/port_ioc_detect_chk.sv
module port_ioc_detect_chk #(
  parameter int PORT_W = 8,
  parameter int IOC_W  = 4
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic [PORT_W-1:0] pins_i,
  input logic [PORT_W-1:0] dir_in_i,
  input logic [IOC_W-1:0]  pin_en_i,
  input logic              glob_en_i,
  input logic              port_rd_i,
  input logic              port_wr_i,
  input logic              flag_clr_i,
  input logic [IOC_W-1:0]  snap,
  input logic              flag_o,
  input logic              irq_o
);
  localparam int LO = PORT_W - IOC_W;
  logic pend;
  assign pend = |((pins_i[PORT_W-1:LO] ^ snap) & pin_en_i & dir_in_i[PORT_W-1:LO]);

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!por_n)
    irq_o |-> (flag_o && glob_en_i));

  assert_clear_blocked_R8: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && pend && !port_rd_i && !port_wr_i) |=> flag_o);

  assert_snap_reload_R7: assert property (@(posedge clk) disable iff (!por_n)
    (port_rd_i || port_wr_i) |=> (snap == $past(pins_i[PORT_W-1:LO])));

  assert_snap_kept_R10: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && !port_rd_i && !port_wr_i) |=> $stable(snap));

  assert_sysreset_flag_R10: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> !flag_o);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!por_n)
    (!flag_o && !pend) |=> !flag_o);
endmodule

bind port_ioc_detect port_ioc_detect_chk #(.PORT_W(PORT_W), .IOC_W(IOC_W)) i_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .pins_i(pins_i), .dir_in_i(dir_in_i),
  .pin_en_i(pin_en_i), .glob_en_i(glob_en_i), .port_rd_i(port_rd_i),
  .port_wr_i(port_wr_i), .flag_clr_i(flag_clr_i), .snap(snap),
  .flag_o(flag_o), .irq_o(irq_o));

// File: tb/test_port_ioc_detect.sv
module test_port_ioc_detect;
  logic clk = 1'b0;
  logic por_n, rst_n, glob_en, rd, wr, clr;
  logic [7:0] pins, dir;
  logic [3:0] en;
  logic flag, irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  port_ioc_detect i_port_ioc_detect (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .pins_i(pins), .dir_in_i(dir),
    .pin_en_i(en), .glob_en_i(glob_en), .port_rd_i(rd), .port_wr_i(wr),
    .flag_clr_i(clr), .flag_o(flag), .irq_o(irq));

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic act_f, logic exp_f, logic act_i, logic exp_i);
    n_chk++;
    if (act_f !== exp_f || act_i !== exp_i) begin
      n_bad++;
      $display("FAIL %s: flag=%b irq=%b expected flag=%b irq=%b", req, act_f, act_i, exp_f, exp_i);
    end
  endtask

  task automatic resync();
    rd = 1'b1; clr = 1'b1; step(); rd = 1'b0; clr = 1'b0; step();
  endtask

  task automatic t_reset();
    por_n = 0; rst_n = 0; pins = 8'h5A; dir = 8'hFF; en = 4'hF; glob_en = 1;
    rd = 0; wr = 0; clr = 0;
    step(3);
    por_n = 1; rst_n = 1;
    step();
    chk("R1 after reset", flag, 1'b0, irq, 1'b0);
    step(3);
    chk("R1 steady pins", flag, 1'b0, irq, 1'b0);
  endtask

  task automatic t_set_clear();
    pins = 8'h4A; step();
    chk("R2 pin4 change", flag, 1'b1, irq, 1'b1);
    pins = 8'h5A; step();
    chk("R2 sticky after revert", flag, 1'b1, irq, 1'b1);
    pins = 8'h4A; clr = 1; step(); clr = 0;
    chk("R8 clear blocked", flag, 1'b1, irq, 1'b1);
    rd = 1; step(); rd = 0;
    chk("R7 read keeps flag", flag, 1'b1, irq, 1'b1);
    clr = 1; step(); clr = 0;
    chk("R9 clear no mismatch", flag, 1'b0, irq, 1'b0);
    pins = 8'h5A; rd = 1; clr = 1; step(); rd = 0; clr = 0;
    step();
    chk("R7 access+clear same cycle", flag, 1'b0, irq, 1'b0);
  endtask

  task automatic t_enable_mask();
    en = 4'b1101; pins = 8'h7A; step(2);
    chk("R3 disabled pin5", flag, 1'b0, irq, 1'b0);
    pins = 8'h5A; step(); en = 4'hF; step();
    dir = 8'h7F; pins = 8'hDA; step(2);
    chk("R4 output pin7", flag, 1'b0, irq, 1'b0);
    pins = 8'h5A; step(); dir = 8'hFF; step();
    pins = 8'h55; dir = 8'hF0; step(2);
    chk("R5 low pins ignored", flag, 1'b0, irq, 1'b0);
    dir = 8'hFF; pins = 8'h5A; step();
  endtask

  task automatic t_global();
    glob_en = 0; pins = 8'hDA; step();
    chk("R6 flag kept irq gated", flag, 1'b1, irq, 1'b0);
    glob_en = 1; #1;
    chk("R6 irq follows enable", flag, 1'b1, irq, 1'b1);
    wr = 1; clr = 1; step(); wr = 0; clr = 0;
    chk("R7 write+clear", flag, 1'b0, irq, 1'b0);
  endtask

  task automatic t_race();
    pins = 8'h9A; rd = 1; step(); rd = 0;
    step(2);
    chk("R11 change during read", flag, 1'b0, irq, 1'b0);
  endtask

  task automatic t_sysreset();
    pins = 8'h1A; step();
    chk("R10 mismatch set", flag, 1'b1, irq, 1'b1);
    rst_n = 0; step();
    chk("R10 reset clears flag", flag, 1'b0, irq, 1'b0);
    rst_n = 1; step();
    chk("R10 flag re-sets", flag, 1'b1, irq, 1'b1);
    pins = 8'h9A; clr = 1; step(); clr = 0;
    chk("R10 snapshot kept", flag, 1'b0, irq, 1'b0);
    resync();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_set_clear();
        t_enable_mask();
        t_global();
        t_race();
        t_sysreset();
      end
      begin
        step(20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule